// File: doc/BRIEF.md
# LCD Scanline Mode Timing Controller

This block produces the line and frame timing for a tile-based LCD controller. A dot counter advances on every clock where the cycle enable is high, and the controller walks each visible line through three phases (object scan, pixel transfer, horizontal blank) before moving to the next line. After the last visible line it spends ten whole lines in vertical blank and then wraps to line 0.

The current line is compared with a programmable compare value. A status byte carries the current mode, the live compare-match flag and an echo of the four status interrupt enables. Two request pulses come out of the block. The vertical-blank request and a frame-ready strobe both fire when vertical blank begins. A merged status request fires when any enabled source becomes active: entry into horizontal blank, entry into vertical blank, entry into object scan, or a rising compare match. Clearing the LCD-enable input parks the block. Setting it again restarts the frame from line 0.

Top module: `lcd_line_timer`

## Requirements
- R1: A line lasts 456 enabled cycles. Object scan (mode 2) covers the first 80, pixel transfer (mode 3) the next 172, and horizontal blank (mode 0) the remaining 204.
- R2: status[1:0] holds the mode, coded 0 = horizontal blank, 1 = vertical blank, 2 = object scan, 3 = pixel transfer. status[6:3] echo irq_en[3:0], and status[7] reads 0.
- R3: The line counter steps by one at the end of each line. A frame has lines 0 to 153, and the enabled cycle after line 153 ends shows line 0 in object scan.
- R4: Lines 144 to 153 are spent entirely in vertical blank (mode 1), each for 456 enabled cycles.
- R5: vblank_irq and frame_strobe are high for exactly the one cycle in which mode 1 and line 144 first appear.
- R6: stat_irq pulses when the mode enters horizontal blank with irq_en[0] set (status bit 3), enters vertical blank with irq_en[1] set (bit 4), or enters object scan with irq_en[2] set (bit 5).
- R7: status[2] is high exactly when line equals the compare value that was applied at the preceding clock edge. A rising edge of this flag pulses stat_irq when irq_en[3] (bit 6) is set.
- R8: stat_irq is a single-cycle pulse. Several enabled sources that become active at the same edge give only one pulse.
- R9: While lcd_on is low, the line reads 0, the mode reads horizontal blank, status[2] reads 0, and no request pulse is produced.
- R10: The first clock edge with lcd_on high after it was low shows line 0 in object scan. This counts as an entry into object scan, and the line then runs its full 456 cycles.
- R11: A cycle with tick low leaves the line, the mode and the dot position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Cycle enable that advances the dot counter |
| lcd_on | input | 1 | LCD enable; low parks the timing |
| irq_en | input | 4 | Status interrupt enables: [0] hblank, [1] vblank, [2] object scan, [3] compare match |
| cmp_line | input | 8 | Line compare value |
| mode | output | 2 | Current mode code |
| line | output | 8 | Current line number |
| status | output | 8 | {0, irq_en, match flag, mode} |
| vblank_irq | output | 1 | Vertical-blank request pulse |
| stat_irq | output | 1 | Merged status request pulse |
| frame_strobe | output | 1 | Frame-ready pulse at vertical-blank entry |

## Verification
Mode, line, the match flag and both request pulses are all registered. Each of them reflects the inputs sampled at a clock edge immediately after that edge, one cycle of latency, with no further pipeline. status[6:3] follows irq_en with no register in between. The bench drives inputs on the falling edge and checks every output at the next falling edge against a reference that it steps in the same cycle. That reference computes line and mode directly from the count of enabled cycles since the LCD was enabled, which keeps every comparison on the cycle where the result is due.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

  localparam int NUM_STAT_SRC = 4;
endpackage

// File: rtl/lcdt_sequencer.sv
module lcdt_sequencer
  import lcdt_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int SCAN_DOTS     = 80,
  parameter int XFER_DOTS     = 172,
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int LINE_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lcd_on,
  output lcd_mode_e         mode_q,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_d,
  output logic              enter_hb,
  output logic              enter_vb,
  output logic              enter_scan
);
  localparam int DOT_W = $clog2(DOTS_PER_LINE);
  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  SCAN_LAST = DOT_W'(SCAN_DOTS - 1);
  localparam logic [DOT_W-1:0]  XFER_LAST = DOT_W'(SCAN_DOTS + XFER_DOTS - 1);
  localparam logic [LINE_W-1:0] VIS_LAST  = LINE_W'(VISIBLE_LINES - 1);
  localparam logic [LINE_W-1:0] VB_FIRST  = LINE_W'(VISIBLE_LINES);
  localparam logic [LINE_W-1:0] FRM_LAST  = LINE_W'(TOTAL_LINES - 1);

  logic [DOT_W-1:0] dot_q, dot_d;
  lcd_mode_e        mode_d;
  logic             on_q;
  logic             last_dot;

  assign last_dot = (dot_q == LAST_DOT);

  // next-state logic
  always_comb begin
    dot_d      = dot_q;
    line_d     = line_q;
    mode_d     = mode_q;
    enter_hb   = 1'b0;
    enter_vb   = 1'b0;
    enter_scan = 1'b0;
    if (!lcd_on) begin
      dot_d  = '0;
      line_d = '0;
      mode_d = MODE_HBLANK;
    end else if (!on_q) begin
      dot_d      = '0;
      line_d     = '0;
      mode_d     = MODE_SCAN;
      enter_scan = 1'b1;
    end else if (tick) begin
      dot_d = last_dot ? '0 : dot_q + DOT_W'(1);
      case (mode_q)
        MODE_SCAN: begin
          if (dot_q == SCAN_LAST) mode_d = MODE_XFER;
        end
        MODE_XFER: begin
          if (dot_q == XFER_LAST) begin
            mode_d   = MODE_HBLANK;
            enter_hb = 1'b1;
          end
        end
        MODE_HBLANK: begin
          if (last_dot) begin
            if (line_q == VIS_LAST) begin
              line_d   = VB_FIRST;
              mode_d   = MODE_VBLANK;
              enter_vb = 1'b1;
            end else begin
              line_d     = line_q + LINE_W'(1);
              mode_d     = MODE_SCAN;
              enter_scan = 1'b1;
            end
          end
        end
        MODE_VBLANK: begin
          if (last_dot) begin
            if (line_q == FRM_LAST) begin
              line_d     = '0;
              mode_d     = MODE_SCAN;
              enter_scan = 1'b1;
            end else begin
              line_d = line_q + LINE_W'(1);
            end
          end
        end
        default: mode_d = MODE_HBLANK;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      dot_q  <= '0;
      line_q <= '0;
      mode_q <= MODE_HBLANK;
    end else begin
      on_q   <= lcd_on;
      dot_q  <= dot_d;
      line_q <= line_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/lcdt_line_match.sv
module lcdt_line_match #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic [LINE_W-1:0] line_d,
  input  logic [LINE_W-1:0] cmp_line,
  output logic              match_q,
  output logic              match_rise
);
  logic match_d;

  always_comb begin
    match_d    = lcd_on && (line_d == cmp_line);
    match_rise = match_d && !match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end
endmodule

// File: rtl/lcdt_irq_merge.sv
module lcdt_irq_merge
  import lcdt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lcd_on,
  input  logic                    enter_hb,
  input  logic                    enter_vb,
  input  logic                    enter_scan,
  input  logic                    match_rise,
  input  logic [NUM_STAT_SRC-1:0] irq_en,
  output logic                    stat_irq_q,
  output logic                    vblank_q
);
  logic [NUM_STAT_SRC-1:0] src;
  logic [NUM_STAT_SRC-1:0] gated;
  logic                    stat_d, vblank_d;

  assign src = {match_rise, enter_scan, enter_vb, enter_hb};

  for (genvar i = 0; i < NUM_STAT_SRC; i++) begin : g_gate
    assign gated[i] = src[i] & irq_en[i];
  end

  always_comb begin
    stat_d   = lcd_on && (|gated);
    vblank_d = lcd_on && enter_vb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_irq_q <= 1'b0;
      vblank_q   <= 1'b0;
    end else begin
      stat_irq_q <= stat_d;
      vblank_q   <= vblank_d;
    end
  end
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcdt_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int SCAN_DOTS     = 80,
  parameter int XFER_DOTS     = 172,
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  localparam int LINE_W       = $clog2(TOTAL_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    lcd_on,
  input  logic [NUM_STAT_SRC-1:0] irq_en,
  input  logic [LINE_W-1:0]       cmp_line,
  output logic [1:0]              mode,
  output logic [LINE_W-1:0]       line,
  output logic [7:0]              status,
  output logic                    vblank_irq,
  output logic                    stat_irq,
  output logic                    frame_strobe
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  lcd_mode_e         mode_q;
  logic [LINE_W-1:0] line_q, line_d;
  logic              enter_hb, enter_vb, enter_scan;
  logic              match_q, match_rise;
  logic              stat_q, vb_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lcdt_sequencer #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .SCAN_DOTS    (SCAN_DOTS),
    .XFER_DOTS    (XFER_DOTS),
    .VISIBLE_LINES(VISIBLE_LINES),
    .TOTAL_LINES  (TOTAL_LINES),
    .LINE_W       (LINE_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .lcd_on    (lcd_on),
    .mode_q    (mode_q),
    .line_q    (line_q),
    .line_d    (line_d),
    .enter_hb  (enter_hb),
    .enter_vb  (enter_vb),
    .enter_scan(enter_scan)
  );

  lcdt_line_match #(.LINE_W(LINE_W)) match_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lcd_on    (lcd_on),
    .line_d    (line_d),
    .cmp_line  (cmp_line),
    .match_q   (match_q),
    .match_rise(match_rise)
  );

  lcdt_irq_merge irq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lcd_on    (lcd_on),
    .enter_hb  (enter_hb),
    .enter_vb  (enter_vb),
    .enter_scan(enter_scan),
    .match_rise(match_rise),
    .irq_en    (irq_en),
    .stat_irq_q(stat_q),
    .vblank_q  (vb_q)
  );

  assign mode         = mode_q;
  assign line         = line_q;
  assign status       = {1'b0, irq_en, match_q, mode_q};
  assign vblank_irq   = vb_q;
  assign frame_strobe = vb_q;
  assign stat_irq     = stat_q;
endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk
  import lcdt_pkg::*;
#(
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int LINE_W        = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              lcd_on,
  input logic [LINE_W-1:0] cmp_line,
  input logic [1:0]        mode,
  input logic [LINE_W-1:0] line,
  input logic [7:0]        status,
  input logic              vblank_irq,
  input logic              stat_irq,
  input logic              frame_strobe
);
  function automatic logic step_ok(input logic [1:0] p, input logic [1:0] c, input logic was_on);
    step_ok = (p == MODE_SCAN   && c == MODE_XFER)
           || (p == MODE_XFER   && c == MODE_HBLANK)
           || (p == MODE_HBLANK && (c == MODE_SCAN || c == MODE_VBLANK))
           || (p == MODE_VBLANK && c == MODE_SCAN)
           || (c == MODE_HBLANK && !was_on);
  endfunction

  // R1: modes follow the per-line order
  a_r1_mode_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> step_ok($past(mode), mode, $past(lcd_on)));

  // R4: vertical blank only on the blank lines
  a_r4_vblank_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_VBLANK) |-> (line >= LINE_W'(VISIBLE_LINES) && line < LINE_W'(TOTAL_LINES)));

  // R5: vertical-blank request only on entry to the first blank line
  a_r5_vblank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (mode == MODE_VBLANK && line == LINE_W'(VISIBLE_LINES) && frame_strobe));

  // R7: match flag agrees with the compare value of the previous edge
  a_r7_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lcd_on) && status[2]) |-> (line == $past(cmp_line)));

  // R9: parked state while the LCD is off
  a_r9_lcd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> (line == '0 && mode == MODE_HBLANK && !stat_irq && !vblank_irq && !status[2]));

  // R11: no progress without the cycle enable
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(lcd_on, 2) && $past(lcd_on) && !$past(tick))
      |-> ($stable(line) && $stable(mode)));

  // R2: top status bit always reads zero
  a_r2_status_top: assert property (@(posedge clk) disable iff (!rst_n) !status[7]);
endmodule

bind lcd_line_timer lcd_line_timer_chk #(
  .VISIBLE_LINES(VISIBLE_LINES),
  .TOTAL_LINES  (TOTAL_LINES),
  .LINE_W       (LINE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .lcd_on      (lcd_on),
  .cmp_line    (cmp_line),
  .mode        (mode),
  .line        (line),
  .status      (status),
  .vblank_irq  (vblank_irq),
  .stat_irq    (stat_irq),
  .frame_strobe(frame_strobe)
);

// File: tb/lcd_line_timer_tb.sv
module lcd_line_timer_tb_top;
  localparam int DPL = 456;
  localparam int TL  = 154;
  localparam int VL  = 144;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       lcd_on;
  logic [3:0] irq_en;
  logic [7:0] cmp_line;
  logic [1:0] mode;
  logic [7:0] line;
  logic [7:0] status;
  logic       vblank_irq, stat_irq, frame_strobe;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  // reference state (value expected after the next edge)
  int   ref_n   = 0;
  bit   ref_on  = 0;
  int   ex_mode = 0;
  int   ex_line = 0;
  bit   ex_match = 0;
  bit   ex_stat = 0;
  bit   ex_vb   = 0;
  bit   ex_multi = 0;
  bit   ex_start = 0;
  bit   ex_tick  = 0;

  lcd_line_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lcd_on(lcd_on),
    .irq_en(irq_en), .cmp_line(cmp_line), .mode(mode), .line(line),
    .status(status), .vblank_irq(vblank_irq), .stat_irq(stat_irq),
    .frame_strobe(frame_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int line_of(input int n);
    return (n / DPL) % TL;
  endfunction

  function automatic int mode_of(input int n);
    int p = n % DPL;
    if (line_of(n) >= VL) return 1;
    if (p < 80)           return 2;
    if (p < 252)          return 3;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    string mtag;
    mtag = !ref_on ? "R9" : ex_start ? "R10" : !ex_tick ? "R11" : (ex_line >= VL) ? "R4" : "R1";
    check(mtag, "mode", mode, ex_mode);
    check(ex_start ? "R10" : "R3", "line", line, ex_line);
    check("R2", "status mode/enables", {status[7:3], status[1:0]}, {1'b0, irq_en, ex_mode[1:0]});
    check("R7", "match flag", status[2], ex_match);
    check("R5", "vblank_irq", vblank_irq, ex_vb);
    check("R5", "frame_strobe", frame_strobe, ex_vb);
    check(ex_multi ? "R8" : "R6", "stat_irq", stat_irq, ex_stat);
  endtask

  // one cycle: check results of the last edge, then drive and step the reference
  task automatic cycle(input bit t, input bit on, input logic [3:0] en, input logic [7:0] cmp);
    int  pm;
    bit  pmatch, entered, s_mode, s_match;
    @(negedge clk);
    check_outputs();
    tick = t; lcd_on = on; irq_en = en; cmp_line = cmp;
    pm = ex_mode; pmatch = ex_match;
    ex_start = 0; ex_tick = t;
    if (!on || !rst_n) begin
      ref_on = 0; ex_mode = 0; ex_line = 0; ex_match = 0;
      ex_stat = 0; ex_vb = 0; ex_multi = 0;
    end else begin
      if (!ref_on) begin ref_on = 1; ref_n = 0; ex_start = 1; end
      else if (t) ref_n++;
      ex_line  = line_of(ref_n);
      ex_mode  = mode_of(ref_n);
      ex_match = (ex_line == int'(cmp));
      entered  = (ex_mode != pm);
      s_mode   = entered && ((ex_mode == 0 && en[0]) || (ex_mode == 1 && en[1]) ||
                             (ex_mode == 2 && en[2]));
      s_match  = ex_match && !pmatch && en[3];
      ex_stat  = s_mode || s_match;
      ex_multi = s_mode && s_match;
      ex_vb    = entered && ex_mode == 1;
    end
  endtask

  initial begin
    int off_left;
    logic [3:0] en;
    logic [7:0] cmp;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; lcd_on = 1'b0; irq_en = 4'h0; cmp_line = 8'h00;
    // reset state (R9 form)
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 4'hF, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 4'hF, 8'd0);

    // directed: one full frame plus wrap, all sources enabled, compare at line 0 (R3 R4 R5 R8 R10)
    cmp = 8'd0;
    for (int i = 0; i < 71500; i++) begin
      if (i == 30000) cmp = 8'd100;
      if (i == 60000) cmp = 8'd150;
      if (i == 70100) cmp = 8'd0;
      cycle(1'b1, 1'b1, 4'hF, cmp);
    end

    // directed: stall with tick low mid-line (R11)
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 4'hF, cmp);

    // directed: switch off then back on (R9 R10)
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 4'hF, 8'd0);
    for (int i = 0; i < 600; i++) cycle(1'b1, 1'b1, 4'b0101, 8'd1);

    // random mix of enables, compare values, stalls and LCD off windows
    en = 4'hF; cmp = 8'd3; off_left = 0;
    for (int i = 0; i < 30000; i++) begin
      if (($urandom % 64) == 0) en = 4'($urandom);
      if (($urandom % 400) == 0) cmp = 8'($urandom % 160);
      if (off_left == 0 && ($urandom % 5000) == 0) off_left = 1 + ($urandom % 5);
      if (off_left > 0) begin
        cycle(1'b1, 1'b0, en, cmp);
        off_left--;
      end else begin
        cycle(($urandom % 4) != 0, 1'b1, en, cmp);
      end
    end
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule